// File: doc/BRIEF.md
# Memory-Card Host Control Register

This block is the main control word of a memory-card host controller. It is a 32-bit register on a simple host bus, with one write strobe and a read-data bus that always shows the current value. It holds the configuration fields of the controller and drives each one to its own output port. These fields are the two card regulator voltage codes, the DMA mode selects, the read-wait request and the command-completion-disable controls. The block also forms the global interrupt line and the active-low open-drain pullup enable for the command line.

Five bits clear themselves, each on its own completion event:
- The DMA reset bit clears after a fixed number of host cycles.
- The FIFO reset bit waits for a done input from the FIFO.
- The abort-read bit waits for the data state machine to report idle.
- The IRQ-response bit waits for the command state machine to report that the response went out.
- The controller reset bit is passed into the card clock domain. It clears only when it has been held for at least two host cycles and the card side has seen it for at least two card cycles. While it is set, it also clears the read-wait, IRQ-response and abort-read bits and an external start-command flag.

Top module: `sdhc_ctl_reg`

## Requirements
- R1: After reset every field reads 0, the read bus is 0, `od_pullup_n` is 1 and every request and field output is 0.
- R2: A write stores bits 4, 5, 6, 9, 10 and 11, regulator-A code in bits 19:16, regulator-B code in bits 23:20, and bits 24 and 25. It shows them on the read bus and on their ports (`volt_a`, `volt_b`, `int_en` bit 4, `dma_en` bit 5, `read_wait` bit 6, `ccsd_send` bit 9, `ccsd_stop` bit 10, `dev_irq_on` bit 11, `use_idma` bit 25). Bits 3, 15:12 and 31:26 always read 0.
- R3: `od_pullup_n` is the inverse of bit 24.
- R4: `irq_out` is 1 exactly when bit 4 is 1 and at least one bit of `irq_pend & irq_allow` is 1.
- R5: Writing 1 to bit 2 (DMA reset) sets it. It and `dma_rst` stay high for exactly two host cycles and then clear.
- R6: Writing 1 to bit 1 (FIFO reset) sets it and `fifo_rst`. The bit holds until a cycle in which `fifo_rst_done` is 1 while it is set, and it is 0 from the next cycle.
- R7: Writing 1 to bit 8 (abort read) sets it and `abort_rd`. It clears the cycle after `data_idle` is 1 while it is set.
- R8: Writing 1 to bit 7 (IRQ response) sets it and `irq_resp_req`. It clears the cycle after `irq_resp_sent` is 1 while it is set.
- R9: Writing 1 to bit 0 (controller reset) sets it and raises `card_rst` in the card domain. The bit clears only after it has been 1 for at least two host cycles and `card_rst` has been 1 for at least two card clock edges, and it does clear within a bounded time.
- R10: While bit 0 is 1, `start_cmd_clr` is 1 and bits 6, 7 and 8 are forced to 0 from the next cycle on, and writes cannot set them. Every other field, including a pending FIFO or DMA reset, is left as it was.
- R11: Writing 0 to a self-clearing bit (0, 1, 2, 7, 8) has no effect. Writing 1 to one that is already set is ignored and does not restart its timing.
- R12: When the write that sets a waiting bit (1, 7 or 8) arrives in the same cycle as that bit's completion input, the bit is set. The completion only acts on a bit that is already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock |
| rst_n | input | 1 | Host-domain asynchronous reset, active low |
| card_clk | input | 1 | Card-side clock |
| card_rst_n | input | 1 | Card-domain asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current register value |
| fifo_rst_done | input | 1 | FIFO reports that its reset is complete |
| data_idle | input | 1 | Data state machine is idle |
| irq_resp_sent | input | 1 | Command state machine has sent the IRQ response |
| irq_pend | input | IRQ_W | Pending interrupt sources |
| irq_allow | input | IRQ_W | Per-source enable (1 = unmasked) |
| fifo_rst | output | 1 | FIFO reset request |
| dma_rst | output | 1 | DMA interface reset pulse |
| card_rst | output | 1 | Controller reset in the card clock domain |
| start_cmd_clr | output | 1 | Clears the external start-command flag |
| abort_rd | output | 1 | Abort-read request to the data state machine |
| irq_resp_req | output | 1 | Request to send the IRQ response |
| read_wait | output | 1 | Read-wait request |
| int_en | output | 1 | Global interrupt enable |
| dma_en | output | 1 | DMA transfer mode enable |
| use_idma | output | 1 | Select the built-in DMA engine |
| ccsd_send | output | 1 | Send command-completion-disable |
| ccsd_stop | output | 1 | Send automatic stop after it |
| dev_irq_on | output | 1 | Device interrupts enabled flag |
| volt_a | output | 4 | Regulator-A voltage code |
| volt_b | output | 4 | Regulator-B voltage code |
| od_pullup_n | output | 1 | Open-drain pullup enable, active low |
| irq_out | output | 1 | Global interrupt |

## Verification
Two events can collide in one cycle. In the first, the controller reset forces the read-wait, abort and IRQ-response bits low while software writes them high. In the second, a completion input such as FIFO done arrives in the very cycle of the write that sets its bit. The bench provokes both on purpose: it writes the abort, response and read-wait bits together with the reset bit and again while the reset is pending, and it raises `fifo_rst_done` during the setting write. A behavioural model gives the reset's force-low and the set-before-clear ordering priority, and every cycle's register value and ports are compared against that model. The controller reset bit is judged against counts of host cycles and card edges observed at the ports, so the exact crossing latency does not enter the check.

// File: rtl/sdhc_ctl_pkg.sv
`timescale 1ns/1ps
package sdhc_ctl_pkg;

    // Bit positions that software and the neighbouring logic decode
    localparam int B_CTL_RST   = 0;
    localparam int B_FIFO_RST  = 1;
    localparam int B_DMA_RST   = 2;
    localparam int B_INT_EN    = 4;
    localparam int B_DMA_EN    = 5;
    localparam int B_RD_WAIT   = 6;
    localparam int B_IRQ_RESP  = 7;
    localparam int B_ABORT     = 8;
    localparam int B_CCSD_SEND = 9;
    localparam int B_CCSD_STOP = 10;
    localparam int B_DEV_IRQ   = 11;
    localparam int VOLT_W      = 4;
    localparam int B_VOLT_A    = 16;
    localparam int B_VOLT_B    = 20;
    localparam int B_OD_PULL   = 24;
    localparam int B_USE_IDMA  = 25;
    localparam int WORD_W      = 32;

    typedef struct packed {
        logic              use_idma;
        logic              od_pull;
        logic [VOLT_W-1:0] volt_b;
        logic [VOLT_W-1:0] volt_a;
        logic              dev_irq;
        logic              ccsd_stop;
        logic              ccsd_send;
        logic              abort;
        logic              irq_resp;
        logic              rd_wait;
        logic              dma_en;
        logic              int_en;
        logic              dma_rst;
        logic              fifo_rst;
        logic              ctl_rst;
    } ctl_word_t;

    function automatic logic [WORD_W-1:0] pack_word(ctl_word_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[B_CTL_RST]                      = c.ctl_rst;
        w[B_FIFO_RST]                     = c.fifo_rst;
        w[B_DMA_RST]                      = c.dma_rst;
        w[B_INT_EN]                       = c.int_en;
        w[B_DMA_EN]                       = c.dma_en;
        w[B_RD_WAIT]                      = c.rd_wait;
        w[B_IRQ_RESP]                     = c.irq_resp;
        w[B_ABORT]                        = c.abort;
        w[B_CCSD_SEND]                    = c.ccsd_send;
        w[B_CCSD_STOP]                    = c.ccsd_stop;
        w[B_DEV_IRQ]                      = c.dev_irq;
        w[B_VOLT_A +: VOLT_W]             = c.volt_a;
        w[B_VOLT_B +: VOLT_W]             = c.volt_b;
        w[B_OD_PULL]                      = c.od_pull;
        w[B_USE_IDMA]                     = c.use_idma;
        return w;
    endfunction

endpackage

// File: rtl/sdhc_sync2.sv
`timescale 1ns/1ps
// Multi-flop level synchronizer into the destination clock domain.
module sdhc_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/sdhc_hold_cnt.sv
`timescale 1ns/1ps
// Counts cycles in which run is high; reached marks the LIMIT-th such cycle
// and stays high while run stays high. Returns to zero whenever run drops.
module sdhc_hold_cnt #(
    parameter int LIMIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic reached
);
    localparam int            CW   = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run)               cnt_d = '0;
        else if (cnt_q != LAST) cnt_d = cnt_q + 1'b1;
        else                    cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign reached = run && (cnt_q == LAST);
endmodule

// File: rtl/sdhc_rst_xdom.sv
`timescale 1ns/1ps
// Carries the controller reset request into the card domain, holds it there
// for CARD_HOLD card cycles, and returns a completion level to the host.
module sdhc_rst_xdom #(
    parameter int CARD_HOLD = 2,
    parameter int STAGES    = 2
) (
    input  logic host_clk,
    input  logic host_rst_n,
    input  logic card_clk,
    input  logic card_rst_n,
    input  logic req,
    output logic card_rst,
    output logic ack
);
    logic card_reached;
    logic done_d, done_q;

    sdhc_sync2 #(.STAGES(STAGES)) u_req_sync (
        .clk   (card_clk),
        .rst_n (card_rst_n),
        .d     (req),
        .q     (card_rst)
    );

    sdhc_hold_cnt #(.LIMIT(CARD_HOLD)) u_card_cnt (
        .clk     (card_clk),
        .rst_n   (card_rst_n),
        .run     (card_rst),
        .reached (card_reached)
    );

    always_comb begin
        done_d = card_rst && (done_q || card_reached);
    end

    always_ff @(posedge card_clk or negedge card_rst_n) begin
        if (!card_rst_n) done_q <= 1'b0;
        else             done_q <= done_d;
    end

    sdhc_sync2 #(.STAGES(STAGES)) u_ack_sync (
        .clk   (host_clk),
        .rst_n (host_rst_n),
        .d     (done_q),
        .q     (ack)
    );
endmodule

// File: rtl/sdhc_ctl_reg.sv
`timescale 1ns/1ps
module sdhc_ctl_reg
    import sdhc_ctl_pkg::*;
#(
    parameter int IRQ_W       = 8,
    parameter int HOST_HOLD   = 2,
    parameter int CARD_HOLD   = 2,
    parameter int DMA_RST_CYC = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                card_clk,
    input  logic                card_rst_n,
    input  logic                reg_wr,
    input  logic [WORD_W-1:0]   reg_wdata,
    output logic [WORD_W-1:0]   reg_rdata,
    input  logic                fifo_rst_done,
    input  logic                data_idle,
    input  logic                irq_resp_sent,
    input  logic [IRQ_W-1:0]    irq_pend,
    input  logic [IRQ_W-1:0]    irq_allow,
    output logic                fifo_rst,
    output logic                dma_rst,
    output logic                card_rst,
    output logic                start_cmd_clr,
    output logic                abort_rd,
    output logic                irq_resp_req,
    output logic                read_wait,
    output logic                int_en,
    output logic                dma_en,
    output logic                use_idma,
    output logic                ccsd_send,
    output logic                ccsd_stop,
    output logic                dev_irq_on,
    output logic [VOLT_W-1:0]   volt_a,
    output logic [VOLT_W-1:0]   volt_b,
    output logic                od_pullup_n,
    output logic                irq_out
);

    ctl_word_t         r_d, r_q;
    logic [WORD_W-1:0] set1;
    logic              host_held;
    logic              dma_done;
    logic              xdom_ack;
    logic              unused_wbits;

    assign set1         = reg_wr ? reg_wdata : '0;
    assign unused_wbits = ^{reg_wdata[3], reg_wdata[15:12], reg_wdata[31:26]};

    // Host-side hold count for the controller reset
    sdhc_hold_cnt #(.LIMIT(HOST_HOLD)) u_host_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (r_q.ctl_rst),
        .reached (host_held)
    );

    // DMA reset pulse length
    sdhc_hold_cnt #(.LIMIT(DMA_RST_CYC)) u_dma_len (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (r_q.dma_rst),
        .reached (dma_done)
    );

    sdhc_rst_xdom #(.CARD_HOLD(CARD_HOLD), .STAGES(SYNC_STAGES)) u_xdom (
        .host_clk   (clk),
        .host_rst_n (rst_n),
        .card_clk   (card_clk),
        .card_rst_n (card_rst_n),
        .req        (r_q.ctl_rst),
        .card_rst   (card_rst),
        .ack        (xdom_ack)
    );

    always_comb begin
        r_d = r_q;

        // Controller reset: a new request waits until the previous
        // acknowledge has returned low.
        if (r_q.ctl_rst) begin
            if (host_held && xdom_ack) r_d.ctl_rst = 1'b0;
        end else if (set1[B_CTL_RST] && !xdom_ack) begin
            r_d.ctl_rst = 1'b1;
        end

        if (r_q.fifo_rst) begin
            if (fifo_rst_done) r_d.fifo_rst = 1'b0;
        end else if (set1[B_FIFO_RST]) begin
            r_d.fifo_rst = 1'b1;
        end

        if (r_q.dma_rst) begin
            if (dma_done) r_d.dma_rst = 1'b0;
        end else if (set1[B_DMA_RST]) begin
            r_d.dma_rst = 1'b1;
        end

        if (r_q.irq_resp) begin
            if (irq_resp_sent) r_d.irq_resp = 1'b0;
        end else if (set1[B_IRQ_RESP]) begin
            r_d.irq_resp = 1'b1;
        end

        if (r_q.abort) begin
            if (data_idle) r_d.abort = 1'b0;
        end else if (set1[B_ABORT]) begin
            r_d.abort = 1'b1;
        end

        // Plain read/write fields
        if (reg_wr) begin
            r_d.int_en    = reg_wdata[B_INT_EN];
            r_d.dma_en    = reg_wdata[B_DMA_EN];
            r_d.rd_wait   = reg_wdata[B_RD_WAIT];
            r_d.ccsd_send = reg_wdata[B_CCSD_SEND];
            r_d.ccsd_stop = reg_wdata[B_CCSD_STOP];
            r_d.dev_irq   = reg_wdata[B_DEV_IRQ];
            r_d.volt_a    = reg_wdata[B_VOLT_A +: VOLT_W];
            r_d.volt_b    = reg_wdata[B_VOLT_B +: VOLT_W];
            r_d.od_pull   = reg_wdata[B_OD_PULL];
            r_d.use_idma  = reg_wdata[B_USE_IDMA];
        end

        // The controller reset wins over writes and completions on its subset
        if (r_q.ctl_rst) begin
            r_d.rd_wait  = 1'b0;
            r_d.irq_resp = 1'b0;
            r_d.abort    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign reg_rdata     = pack_word(r_q);
    assign fifo_rst      = r_q.fifo_rst;
    assign dma_rst       = r_q.dma_rst;
    assign start_cmd_clr = r_q.ctl_rst;
    assign abort_rd      = r_q.abort;
    assign irq_resp_req  = r_q.irq_resp;
    assign read_wait     = r_q.rd_wait;
    assign int_en        = r_q.int_en;
    assign dma_en        = r_q.dma_en;
    assign use_idma      = r_q.use_idma;
    assign ccsd_send     = r_q.ccsd_send;
    assign ccsd_stop     = r_q.ccsd_stop;
    assign dev_irq_on    = r_q.dev_irq;
    assign volt_a        = r_q.volt_a;
    assign volt_b        = r_q.volt_b;
    assign od_pullup_n   = ~r_q.od_pull;
    assign irq_out       = r_q.int_en && |(irq_pend & irq_allow);

endmodule

// File: rtl/sdhc_ctl_reg_chk.sv
`timescale 1ns/1ps
module sdhc_ctl_reg_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] reg_rdata,
    input logic        fifo_rst_done,
    input logic        data_idle,
    input logic        irq_resp_sent,
    input logic        fifo_rst,
    input logic        dma_rst,
    input logic        start_cmd_clr,
    input logic        abort_rd,
    input logic        irq_resp_req,
    input logic        read_wait,
    input logic        irq_out,
    input logic        od_pullup_n
);
    // R3
    od_inverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        od_pullup_n == !reg_rdata[24]);

    // R4
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> reg_rdata[4]);

    // R5
    dma_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_rst) |=> dma_rst);

    // R6
    fifo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rst && !fifo_rst_done |=> fifo_rst);

    // R6
    fifo_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rst && fifo_rst_done |=> !fifo_rst);

    // R7
    abort_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_rd && data_idle |=> !abort_rd);

    // R8
    resp_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_resp_req && irq_resp_sent |=> !irq_resp_req);

    // R9
    ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(start_cmd_clr) |-> $past(start_cmd_clr, 2));

    // R10
    ctl_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_cmd_clr && $past(start_cmd_clr) |-> !abort_rd && !irq_resp_req && !read_wait);
endmodule

bind sdhc_ctl_reg sdhc_ctl_reg_chk u_chk (.*);

// File: tb/sdhc_ctl_reg_test.sv
`timescale 1ns/1ps
module sdhc_ctl_reg_test;
    localparam int IRQ_W = 8;

    logic             clk = 1'b0, card_clk = 1'b0, rst_n = 1'b0;
    logic             reg_wr = 1'b0;
    logic [31:0]      reg_wdata = '0;
    logic [31:0]      reg_rdata;
    logic             fifo_rst_done = 1'b0, data_idle = 1'b0, irq_resp_sent = 1'b0;
    logic [IRQ_W-1:0] irq_pend = '0, irq_allow = '0;
    logic fifo_rst, dma_rst, card_rst, start_cmd_clr, abort_rd, irq_resp_req, read_wait;
    logic int_en, dma_en, use_idma, ccsd_send, ccsd_stop, dev_irq_on, od_pullup_n, irq_out;
    logic [3:0] volt_a, volt_b;

    always #2   clk = ~clk;
    always #3.5 card_clk = ~card_clk;

    sdhc_ctl_reg uut (
        .clk(clk), .rst_n(rst_n), .card_clk(card_clk), .card_rst_n(rst_n),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fifo_rst_done(fifo_rst_done), .data_idle(data_idle), .irq_resp_sent(irq_resp_sent),
        .irq_pend(irq_pend), .irq_allow(irq_allow),
        .fifo_rst(fifo_rst), .dma_rst(dma_rst), .card_rst(card_rst), .start_cmd_clr(start_cmd_clr),
        .abort_rd(abort_rd), .irq_resp_req(irq_resp_req), .read_wait(read_wait), .int_en(int_en),
        .dma_en(dma_en), .use_idma(use_idma), .ccsd_send(ccsd_send), .ccsd_stop(ccsd_stop),
        .dev_irq_on(dev_irq_on), .volt_a(volt_a), .volt_b(volt_b),
        .od_pullup_n(od_pullup_n), .irq_out(irq_out)
    );

    int n_run = 0, n_fail = 0;
    bit run_chk = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit m_b0, m_b1, m_b2, m_b4, m_b5, m_b6, m_b7, m_b8, m_b9, m_b10, m_b11, m_b24, m_b25;
    logic [3:0] m_va, m_vb;
    int dma_left, hc, ce;

    function automatic logic [31:0] m_word();
        logic [31:0] w = '0;
        w[0] = m_b0; w[1] = m_b1; w[2] = m_b2; w[4] = m_b4; w[5] = m_b5;
        w[6] = m_b6; w[7] = m_b7; w[8] = m_b8; w[9] = m_b9; w[10] = m_b10;
        w[11] = m_b11; w[19:16] = m_va; w[23:20] = m_vb; w[24] = m_b24; w[25] = m_b25;
        return w;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            {m_b0, m_b1, m_b2, m_b4, m_b5, m_b6, m_b7, m_b8} = '0;
            {m_b9, m_b10, m_b11, m_b24, m_b25} = '0;
            m_va = '0; m_vb = '0; dma_left = 0; hc = 0;
        end else begin
            bit old_b0;
            old_b0 = m_b0;
            if (old_b0) hc++;
            if (!old_b0 && reg_wr && reg_wdata[0]) begin m_b0 = 1; hc = 0; ce = 0; end
            if (m_b1) begin if (fifo_rst_done) m_b1 = 0; end
            else if (reg_wr && reg_wdata[1]) m_b1 = 1;
            if (m_b2) begin dma_left--; if (dma_left == 0) m_b2 = 0; end
            else if (reg_wr && reg_wdata[2]) begin m_b2 = 1; dma_left = 2; end
            if (m_b7) begin if (irq_resp_sent) m_b7 = 0; end
            else if (reg_wr && reg_wdata[7]) m_b7 = 1;
            if (m_b8) begin if (data_idle) m_b8 = 0; end
            else if (reg_wr && reg_wdata[8]) m_b8 = 1;
            if (reg_wr) begin
                m_b4 = reg_wdata[4]; m_b5 = reg_wdata[5]; m_b6 = reg_wdata[6];
                m_b9 = reg_wdata[9]; m_b10 = reg_wdata[10]; m_b11 = reg_wdata[11];
                m_va = reg_wdata[19:16]; m_vb = reg_wdata[23:20];
                m_b24 = reg_wdata[24]; m_b25 = reg_wdata[25];
            end
            if (old_b0) begin m_b6 = 0; m_b7 = 0; m_b8 = 0; end
        end
    end

    always @(posedge card_clk) if (card_rst) ce++;

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && run_chk) begin
            if (m_b0 && !reg_rdata[0]) begin
                chk(hc >= 2 && ce >= 2, "R9 reset held two host and two card cycles",
                    32'(hc * 256 + ce), 32'h0202);
                m_b0 = 0;
            end
            if (m_b0 && hc > 60) begin
                chk(0, "R9 controller reset never cleared", reg_rdata, 32'h0);
                m_b0 = 0;
            end
            chk(reg_rdata[0] == m_b0, "R9 bit0", reg_rdata, m_word());
            chk(reg_rdata[1] == m_b1 && fifo_rst == m_b1, "R6 fifo reset", reg_rdata, m_word());
            chk(reg_rdata[2] == m_b2 && dma_rst == m_b2, "R5 dma reset", reg_rdata, m_word());
            chk(reg_rdata[7] == m_b7 && irq_resp_req == m_b7, "R8 irq response", reg_rdata, m_word());
            chk(reg_rdata[8] == m_b8 && abort_rd == m_b8, "R7 abort read", reg_rdata, m_word());
            chk(reg_rdata[6] == m_b6 && read_wait == m_b6 && start_cmd_clr == m_b0,
                "R10 reset subset", reg_rdata, m_word());
            chk(reg_rdata[31:3] == m_word() >> 3 && volt_a == m_va && volt_b == m_vb
                && int_en == m_b4 && dma_en == m_b5 && ccsd_send == m_b9 && ccsd_stop == m_b10
                && dev_irq_on == m_b11 && use_idma == m_b25, "R2 fields", reg_rdata, m_word());
            chk(od_pullup_n == !m_b24, "R3 pullup", 32'(od_pullup_n), 32'(!m_b24));
            chk(irq_out == (m_b4 && |(irq_pend & irq_allow)), "R4 interrupt",
                32'(irq_out), 32'(m_b4 && |(irq_pend & irq_allow)));
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr_reg(input logic [31:0] d);
        @(negedge clk); #1 reg_wr = 1'b1; reg_wdata = d;
        @(posedge clk); #1 reg_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_ctl_clear();
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (!reg_rdata[0]) break;
        end
    endtask

    initial begin
        #(4 * 150000);
        chk(0, "watchdog", 32'h0, 32'h1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        idle(5);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(reg_rdata == 0 && od_pullup_n && !irq_out && !card_rst && !fifo_rst && !dma_rst
            && !start_cmd_clr && volt_a == 0 && volt_b == 0, "R1 reset state", reg_rdata, 32'h0);
        run_chk = 1;

        // R2 all plain fields and reserved bits set
        wr_reg(32'hFFFF_FE78);
        @(negedge clk);
        chk(reg_rdata == 32'h03FF_0E70, "R2 reserved read zero", reg_rdata, 32'h03FF_0E70);
        chk(od_pullup_n == 1'b0, "R3 pullup low when bit24 set", 32'(od_pullup_n), 32'h0);
        wr_reg(32'h01A5_0030);
        @(negedge clk);
        chk(volt_a == 4'h5 && volt_b == 4'hA, "R2 voltage ports", {24'h0, volt_b, volt_a}, 32'hA5);
        wr_reg(32'h0000_0010);
        @(negedge clk);
        chk(od_pullup_n == 1'b1, "R3 pullup high when bit24 clear", 32'(od_pullup_n), 32'h1);

        // R4 interrupt gating
        #1 irq_pend = 8'h04; irq_allow = 8'h00;
        @(negedge clk);
        chk(!irq_out, "R4 masked source", 32'(irq_out), 32'h0);
        #1 irq_allow = 8'h0C;
        @(negedge clk);
        chk(irq_out, "R4 unmasked source", 32'(irq_out), 32'h1);
        wr_reg(32'h0);
        @(negedge clk);
        chk(!irq_out, "R4 global enable off", 32'(irq_out), 32'h0);

        // R5 DMA reset two cycles, R11 re-write while pending ignored
        wr_reg(32'h4);
        wr_reg(32'h4);
        @(negedge clk);
        chk(dma_rst, "R5 second cycle", 32'(dma_rst), 32'h1);
        @(negedge clk);
        chk(!dma_rst, "R11 re-write did not restart dma timing", 32'(dma_rst), 32'h0);

        // R6 FIFO reset waits for done; R11 write of 0 ignored
        wr_reg(32'h2);
        idle(4);
        wr_reg(32'h0);
        @(negedge clk);
        chk(fifo_rst, "R11 write zero ignored on fifo bit", 32'(fifo_rst), 32'h1);
        #1 fifo_rst_done = 1'b1;
        @(negedge clk); #1 fifo_rst_done = 1'b0;
        chk(!fifo_rst, "R6 cleared after done", 32'(fifo_rst), 32'h0);

        // R12 done in the same cycle as the setting write
        @(negedge clk); #1 fifo_rst_done = 1'b1; reg_wr = 1'b1; reg_wdata = 32'h2;
        @(posedge clk); #1 reg_wr = 1'b0; fifo_rst_done = 1'b0;
        @(negedge clk);
        chk(fifo_rst, "R12 set wins over simultaneous done", 32'(fifo_rst), 32'h1);
        #1 fifo_rst_done = 1'b1;
        @(negedge clk); #1 fifo_rst_done = 1'b0;

        // R7 abort, R8 irq response
        wr_reg(32'h180);
        idle(3);
        chk(abort_rd && irq_resp_req, "R7 R8 held while waiting", reg_rdata, 32'h180);
        #1 data_idle = 1'b1;
        @(negedge clk); #1 data_idle = 1'b0;
        chk(!abort_rd && irq_resp_req, "R7 abort cleared by idle", reg_rdata, 32'h80);
        #1 irq_resp_sent = 1'b1;
        @(negedge clk); #1 irq_resp_sent = 1'b0;
        chk(!irq_resp_req, "R8 response cleared", reg_rdata, 32'h0);

        // R9 R10 controller reset with collisions
        wr_reg(32'h00F0_01C2);          // fifo pending, volts, subset bits set
        wr_reg(32'h00F0_01C3);          // start controller reset
        @(negedge clk);
        chk(start_cmd_clr, "R10 start command clear raised", 32'(start_cmd_clr), 32'h1);
        wr_reg(32'h00F0_01C1);          // R11 write 1 while pending; R10 subset write blocked
        @(negedge clk);
        chk(!read_wait && !abort_rd && !irq_resp_req, "R10 subset forced low", reg_rdata, 32'h00F0_0003);
        wait_ctl_clear();
        chk(!reg_rdata[0], "R9 reset bit cleared", reg_rdata, 32'h00F0_0002);
        chk(volt_b == 4'hF && fifo_rst, "R10 other fields untouched", reg_rdata, 32'h00F0_0002);
        #1 fifo_rst_done = 1'b1;
        @(negedge clk); #1 fifo_rst_done = 1'b0;
        idle(30);

        // Second controller reset with card edges observed
        wr_reg(32'h1);
        idle(3);
        chk(reg_rdata[0], "R9 held early", reg_rdata, 32'h1);
        wait_ctl_clear();
        idle(30);
        chk(!card_rst, "R9 card reset released", 32'(card_rst), 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule